// File: doc/BRIEF.md
# Tri-State Phase-Frequency Comparator with Lock Monitor

This block compares a reference pulse train against a divided-down loop pulse train. It runs on the oscillator clock. For each pair of pulses it raises a pump request that lasts as long as the phase error. The request appears as a 2-bit code that tells an output stage to drive high, drive low or float. A polarity input selects which pump direction a leading reference produces, so the block can serve loops whose oscillator tuning slope is positive or negative.

The block has two sequential request flags. The first rising edge of either input sets its own flag. When both flags would be set, both are cleared. A second reference edge that arrives before the loop edge therefore extends the request, which lets the block discriminate frequency as well as phase.

A lock monitor measures the width of each error pulse in oscillator clocks. It raises a lock flag after a run of narrow errors and drops the flag as soon as an error grows wide. A power-save input quiets the block at once. The pump code floats, the lock flag goes low, and all detector state is cleared.

Top module: `pfd_tristate`

## Requirements
- R1: After reset, the pump code is 2'b00 (float) and the lock flag is low.
- R2: The pump code uses 2'b01 for drive high, 2'b10 for drive low and 2'b00 for float, and never shows 2'b11. With polarity high, suppose a reference rising edge is sampled at clock edge k and a loop rising edge at edge k+d (d ≥ 1). Then the code is 2'b01 in each of the d cycles that follow edge k, and it returns to 2'b00 after edge k+d.
- R3: With polarity high, a loop edge that leads the reference edge by d cycles gives drive low (2'b10) for d cycles, followed by float.
- R4: With polarity low, both directions are swapped: a leading reference gives 2'b10 and a leading loop edge gives 2'b01.
- R5: Rising edges on both inputs at the same clock edge leave the code at float. Such a comparison counts as a zero-width error.
- R6: Further reference edges that arrive while a reference request is pending keep the request active. It stays active until the next loop edge clears it.
- R7: A comparison is narrow when its error width is below both UNLOCK_CYC (default 2) and LOCK_CYC (default 4). After LOCK_COUNT (default 3) narrow comparisons in a row, the lock flag rises at the clock edge that ends the last one.
- R8: An error pulse drops the lock flag and restarts the run of narrow comparisons at the clock edge where its running width reaches UNLOCK_CYC. With the default, a width of exactly 2 clocks drops lock and a width of 1 keeps it.
- R9: While power-save is high, the code is float and the lock flag is low in the same cycle. Pending requests, the width count and the narrow run are all cleared, so the next lone edge starts a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | Reference pulse, rising edge is used |
| fb_i | input | 1 | Divided loop pulse, rising edge is used |
| polarity_i | input | 1 | 1: leading reference drives high; 0: swapped |
| pwr_save_i | input | 1 | Power-save, forces float and clears state |
| pump_o | output | 2 | Pump code: 00 float, 01 drive high, 10 drive low |
| lock_o | output | 1 | Lock flag |

## Verification
Input edges are registered once. The pump code is then a plain function of the two request flags, so a stimulus applied before edge k shows on the code in the cycle after edge k. The lock flag changes at the same edge that ends a narrow comparison, or at the edge where a wide error reaches UNLOCK_CYC. Power-save and polarity act on the outputs with no clock delay. The bench changes inputs on falling edges and samples on the next falling edge, one register stage later. For the combinational paths it samples a time step after the drive, in the same low phase.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef enum logic [1:0] {
      PUMP_FLOAT = 2'b00,
      PUMP_HIGH  = 2'b01,
      PUMP_LOW   = 2'b10
   } pump_code_e;
endpackage

// File: rtl/pfd_edge_rise.sv
module pfd_edge_rise #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);
   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_bit
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl_i[g];
         end
         assign rise_o[g] = lvl_i[g] & ~prev_q;
      end
   endgenerate
endmodule

// File: rtl/pfd_flops.sv
module pfd_flops (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic ref_rise_i,
   input  logic fb_rise_i,
   output logic up_o,
   output logic dn_o,
   output logic resolve_o
);
   logic up_q, dn_q, up_nx, dn_nx;

   assign up_nx     = up_q | ref_rise_i;
   assign dn_nx     = dn_q | fb_rise_i;
   assign resolve_o = up_nx & dn_nx & ~clr_i;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (up_nx && dn_nx) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_nx;
         dn_q <= dn_nx;
      end
   end

   assign up_o = up_q;
   assign dn_o = dn_q;
endmodule

// File: rtl/pfd_lock_meter.sv
module pfd_lock_meter #(
   parameter int UNLOCK_CYC = 2,
   parameter int LOCK_CYC   = 4,
   parameter int LOCK_COUNT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic err_i,
   input  logic resolve_i,
   output logic lock_o
);
   localparam int CW = $clog2(LOCK_CYC + 1);
   localparam int WW = CW + 1;
   localparam int SW = (LOCK_COUNT > 1) ? $clog2(LOCK_COUNT) : 1;
   localparam logic [CW-1:0] SAT       = CW'(LOCK_CYC);
   localparam logic [CW-1:0] UNLOCK_M1 = CW'(UNLOCK_CYC - 1);
   localparam logic [WW-1:0] LOCK_W    = WW'(LOCK_CYC);
   localparam logic [SW-1:0] RUN_TOP   = SW'(LOCK_COUNT - 1);

   logic [CW-1:0] width_q;
   logic [WW-1:0] width_now;
   logic [SW-1:0] run_q;
   logic          lock_q, wide, narrow;

   assign width_now = {1'b0, width_q} + {{CW{1'b0}}, err_i};
   assign wide      = err_i && (width_q >= UNLOCK_M1);
   assign narrow    = resolve_i && !wide && (width_now < LOCK_W);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         width_q <= '0;
         run_q   <= '0;
         lock_q  <= 1'b0;
      end else begin
         if (resolve_i)                 width_q <= '0;
         else if (err_i && width_q < SAT) width_q <= width_q + 1'b1;

         if (wide) begin
            lock_q <= 1'b0;
            run_q  <= '0;
         end else if (narrow) begin
            if (run_q == RUN_TOP) lock_q <= 1'b1;
            else                  run_q  <= run_q + 1'b1;
         end
      end
   end

   assign lock_o = lock_q;
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
   parameter int UNLOCK_CYC = 2,
   parameter int LOCK_CYC   = 4,
   parameter int LOCK_COUNT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_i,
   input  logic       fb_i,
   input  logic       polarity_i,
   input  logic       pwr_save_i,
   output logic [1:0] pump_o,
   output logic       lock_o
);
   import pfd_pkg::*;

   generate
      if (UNLOCK_CYC < 1) begin : g_bad_unlock
         $error("UNLOCK_CYC must be at least 1");
      end
      if (LOCK_CYC < UNLOCK_CYC) begin : g_bad_order
         $error("LOCK_CYC must not be below UNLOCK_CYC");
      end
      if (LOCK_COUNT < 1) begin : g_bad_count
         $error("LOCK_COUNT must be at least 1");
      end
   endgenerate

   logic [1:0] rise;
   logic       up, dn, resolve, lock_raw;
   pump_code_e code;

   pfd_edge_rise #(.N(2)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({fb_i, ref_i}),
      .rise_o (rise)
   );

   pfd_flops u_flops (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (pwr_save_i),
      .ref_rise_i (rise[0]),
      .fb_rise_i  (rise[1]),
      .up_o       (up),
      .dn_o       (dn),
      .resolve_o  (resolve)
   );

   pfd_lock_meter #(
      .UNLOCK_CYC (UNLOCK_CYC),
      .LOCK_CYC   (LOCK_CYC),
      .LOCK_COUNT (LOCK_COUNT)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (pwr_save_i),
      .err_i     (up | dn),
      .resolve_i (resolve),
      .lock_o    (lock_raw)
   );

   always_comb begin
      code = PUMP_FLOAT;
      if (!pwr_save_i) begin
         if (up)      code = polarity_i ? PUMP_HIGH : PUMP_LOW;
         else if (dn) code = polarity_i ? PUMP_LOW  : PUMP_HIGH;
      end
   end

   assign pump_o = code;
   assign lock_o = lock_raw & ~pwr_save_i;
endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk #(
   parameter int UNLOCK_CYC = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ref_i,
   input logic       fb_i,
   input logic       polarity_i,
   input logic       pwr_save_i,
   input logic [1:0] pump_o,
   input logic       lock_o
);
   import pfd_pkg::*;

   logic ref_d, fb_d, ref_up, fb_up;
   int   run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_d <= 1'b0;
         fb_d  <= 1'b0;
         run   <= 0;
      end else begin
         ref_d <= ref_i;
         fb_d  <= fb_i;
         if (pump_o == PUMP_FLOAT) run <= 0;
         else if (run < 100000)    run <= run + 1;
      end
   end

   assign ref_up = ref_i & ~ref_d;
   assign fb_up  = fb_i & ~fb_d;

   assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pump_o != 2'b11);

   assert_save_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save_i |-> (pump_o == PUMP_FLOAT && !lock_o));

   assert_inphase_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_up && fb_up && pump_o == PUMP_FLOAT && !pwr_save_i) |=> (pump_o == PUMP_FLOAT));

   assert_lead_sense_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_up && !fb_up && pump_o == PUMP_FLOAT && !pwr_save_i)
      |=> (pwr_save_i || pump_o == (polarity_i ? PUMP_HIGH : PUMP_LOW)));

   assert_wide_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run >= UNLOCK_CYC - 1 && pump_o != PUMP_FLOAT) |=> !lock_o);
endmodule

bind pfd_tristate pfd_tristate_chk #(.UNLOCK_CYC(UNLOCK_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_i      (ref_i),
   .fb_i       (fb_i),
   .polarity_i (polarity_i),
   .pwr_save_i (pwr_save_i),
   .pump_o     (pump_o),
   .lock_o     (lock_o)
);

// File: tb/pfd_tristate_tb.sv
module pfd_tristate_tb_top;
   localparam logic [1:0] FLT = 2'b00, HI = 2'b01, LO = 2'b10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_i = 1'b0, fb_i = 1'b0, polarity_i = 1'b1, pwr_save_i = 1'b0;
   logic [1:0] pump_o;
   logic       lock_o;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   pfd_tristate dut_i (
      .clk (clk), .rst_n (rst_n), .ref_i (ref_i), .fb_i (fb_i),
      .polarity_i (polarity_i), .pwr_save_i (pwr_save_i),
      .pump_o (pump_o), .lock_o (lock_o)
   );

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one comparison, ref or loop edge leading by d cycles; starts and ends at a falling edge
   task automatic compare(input logic pol, input bit ref_first, input int d, input string req);
      logic [1:0] exp;
      exp = (ref_first ~^ pol) ? HI : LO;
      polarity_i = pol;
      for (int i = 0; i <= d; i++) begin
         ref_i = ref_first ? (i == 0) : (i == d);
         fb_i  = ref_first ? (i == d) : (i == 0);
         @(negedge clk);
         chk(req, pump_o, (i < d) ? exp : FLT);
      end
      ref_i = 1'b0;
      fb_i  = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 code", pump_o, FLT);
      chk("R1 lock", {1'b0, lock_o}, 2'b00);
   endtask

   task automatic t_directions();
      compare(1'b1, 1'b1, 3, "R2 ref leads pol1");
      compare(1'b1, 1'b0, 2, "R3 fb leads pol1");
      compare(1'b0, 1'b1, 2, "R4 ref leads pol0");
      compare(1'b0, 1'b0, 1, "R4 fb leads pol0");
      compare(1'b1, 1'b1, 0, "R5 in phase");
   endtask

   task automatic t_repeat_ref();
      polarity_i = 1'b1;
      for (int i = 0; i <= 4; i++) begin
         ref_i = (i == 0 || i == 2);
         fb_i  = (i == 4);
         @(negedge clk);
         chk("R6 repeated ref", pump_o, (i < 4) ? HI : FLT);
      end
      ref_i = 1'b0;
      fb_i  = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_lock();
      compare(1'b1, 1'b1, 1, "R7 narrow");
      compare(1'b1, 1'b0, 1, "R7 narrow");
      chk("R7 not yet locked", {1'b0, lock_o}, 2'b00);
      compare(1'b1, 1'b1, 1, "R7 narrow");
      chk("R7 locked after three", {1'b0, lock_o}, 2'b01);
      compare(1'b1, 1'b1, 1, "R8 width 1 keeps");
      chk("R8 width 1 keeps lock", {1'b0, lock_o}, 2'b01);
      compare(1'b1, 1'b1, 2, "R8 width 2");
      chk("R8 width 2 drops lock", {1'b0, lock_o}, 2'b00);
      compare(1'b1, 1'b1, 0, "R5 zero width");
      compare(1'b1, 1'b1, 0, "R5 zero width");
      chk("R8 run restarted", {1'b0, lock_o}, 2'b00);
      compare(1'b1, 1'b0, 1, "R7 narrow");
      chk("R5 in-phase counted toward lock", {1'b0, lock_o}, 2'b01);
      compare(1'b1, 1'b0, 3, "R8 width 3");
      chk("R8 width 3 drops lock", {1'b0, lock_o}, 2'b00);
      repeat (3) compare(1'b1, 1'b1, 1, "R7 relock");
      chk("R7 relocked", {1'b0, lock_o}, 2'b01);
   endtask

   task automatic t_power_save();
      polarity_i = 1'b1;
      ref_i = 1'b1;
      @(negedge clk);
      ref_i = 1'b0;
      chk("R9 request before save", pump_o, HI);
      pwr_save_i = 1'b1;
      #1;
      chk("R9 save floats", pump_o, FLT);
      chk("R9 save drops lock", {1'b0, lock_o}, 2'b00);
      @(negedge clk);
      pwr_save_i = 1'b0;
      #1;
      chk("R9 request cleared", pump_o, FLT);
      chk("R9 lock stays low", {1'b0, lock_o}, 2'b00);
      @(negedge clk);
      fb_i = 1'b1;
      @(negedge clk);
      fb_i = 1'b0;
      chk("R9 fresh loop request", pump_o, LO);
      ref_i = 1'b1;
      @(negedge clk);
      ref_i = 1'b0;
      chk("R9 fresh request resolved", pump_o, FLT);
      idle(1);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_directions();
      t_repeat_ref();
      t_lock();
      t_power_save();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule